// File: doc/BRIEF.md
# Multi-mode DMA channel sequencer

This block is one DMA channel that copies data units from a source address to a destination address. Each unit takes two bus cycles on its master port: a read at the source pointer, then a write of the captured value at the destination pointer. Software programs the pointers, a transfer count, a block length and a control word through a small register port while the channel is disabled. A hardware trigger input then starts work.

The mode field decides how much work one trigger buys. It can be one unit, the whole counted run, or one block of units. Units are either bytes or half-words, and both pointers advance by the unit size after every unit. When the count runs out, the channel drops its own enable bit and raises a one-cycle done pulse. It then stays quiet until software rearms it.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the control register (offset 0) reads 0: enable bit 0 = 0, dual bit 1 = 0, mode bits [3:2] = 00, size bit 4 = 0 (byte). `done` and `bus_req` are low.
- R2: With mode 00 (single), each trigger moves exactly one unit and lowers the count (offset 3) by one. The channel then waits for the next trigger.
- R3: With mode 01 (successive), one trigger moves units back to back until the count reaches zero.
- R4: With mode 10 (block), each trigger moves the number of units held in the block-length register (offset 4). The count drops by one per block.
- R5: Mode 11 behaves exactly as mode 00.
- R6: Size bit 0 moves bytes. The pointers (offsets 1 and 2) advance by 1, `bus_half` is 0, and the written data is the low byte of the read data with the upper byte zero. Size bit 1 moves half-words, the pointers advance by 2 and `bus_half` is 1.
- R7: While the enable bit is 1, register writes to every offset are ignored.
- R8: When the count reaches zero, the enable bit clears, `done` is high for exactly one cycle, and later triggers start no bus cycle.
- R9: A trigger that arrives while a unit or run is in progress is ignored and is not queued.
- R10: A trigger starts nothing if the enable bit is 0, the dual bit is 0, or the count is 0.
- R11: Each unit is a read of the source pointer followed by a write to the destination pointer of the data read. `bus_req`, `bus_we` and `bus_addr` hold steady until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 control, 1 source, 2 destination, 3 count, 4 block length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (live pointers and count) |
| trig | input | 1 | Hardware transfer trigger |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_half | output | 1 | 1 = half-word cycle, 0 = byte cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Completes the current bus cycle |
| done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench drives a memory with one wait state and with none. A scoreboard predicts every read and write address and every written value, so a wrong pointer step, a lost upper-byte clear or an extra unit shows up at once as a mismatch.

Block mode is run across two triggers. This catches a design that decrements the count per unit, which would finish after the first block. A second trigger is fired in the middle of a single-mode unit; a design that queues triggers would issue an unexpected second unit. Writes made while the channel is enabled are read back unchanged, and the following trigger must resume at the old pointer. Triggers after completion, with the dual bit clear or with a zero count, must produce no bus cycle at all.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   localparam int unsigned UNIT_W = 16;

   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_SRC  = 3'd1;
   localparam logic [2:0] OFS_DST  = 3'd2;
   localparam logic [2:0] OFS_CNT  = 3'd3;
   localparam logic [2:0] OFS_BLK  = 3'd4;

   typedef enum logic [1:0] {
      XM_SINGLE = 2'b00,
      XM_SUCC   = 2'b01,
      XM_BLOCK  = 2'b10,
      XM_RSVD   = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;

   // bit 4 size, bits 3:2 mode, bit 1 dual, bit 0 enable
   typedef struct packed {
      logic       unit_half;
      xfer_mode_e mode;
      logic       dual;
      logic       en;
   } ctrl_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_seq_pkg::*;
#(
   parameter int unsigned BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [31:0]   wr_data,
   input  logic          finish,
   output ctrl_t         ctrl,
   output logic [BW-1:0] blklen
);

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   logic accept;
   assign accept = wr_en && !ctrl.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         blklen <= BW'(1);
      end else if (finish) begin
         ctrl.en <= 1'b0;
      end else if (accept) begin
         if (wr_addr == OFS_CTRL) ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == OFS_BLK)  blklen <= wr_data[BW-1:0];
      end
   end

   // R7: configuration frozen while the channel stays enabled
   p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en |=> ($stable(blklen) && $stable(ctrl.mode) &&
                   $stable(ctrl.unit_half) && $stable(ctrl.dual)));

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          half,
   output logic [AW-1:0] src_ptr,
   output logic [AW-1:0] dst_ptr
);

   localparam int unsigned NPTR = 2;

   logic [AW-1:0] ptr_q [NPTR];
   logic [AW-1:0] inc;

   assign inc = half ? AW'(2) : AW'(1);

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr_q[g] <= '0;
         else if (load[g]) ptr_q[g] <= load_val;
         else if (step)    ptr_q[g] <= ptr_q[g] + inc;
      end

      // R6: each finished unit moves the pointer by the unit size
      p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !load[g]) |=> ptr_q[g] == $past(ptr_q[g]) + ($past(half) ? AW'(2) : AW'(1)));
   end

   assign src_ptr = ptr_q[0];
   assign dst_ptr = ptr_q[1];

endmodule

// File: rtl/dma_count.sv
module dma_count #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          cnt_zero,
   output logic          cnt_one
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - CW'(1);
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_one  = (cnt == CW'(1));

   // R8: the counter never wraps below zero
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt != '0);

   // R2: one decrement per accounted unit or block
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_seq_pkg::*;
#(
   parameter int unsigned BW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  ctrl_t             ctrl,
   input  logic [BW-1:0]     blklen,
   input  logic              cnt_zero,
   input  logic              cnt_one,
   input  logic              bus_ack,
   input  logic [UNIT_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [UNIT_W-1:0] wdata,
   output logic              step,
   output logic              cnt_dec,
   output logic              finish,
   output logic              done
);

   seq_state_e        state, state_nx;
   logic [BW-1:0]     blk_left;
   logic              armed, start, unit_end, blk_last;
   logic              is_block, is_succ;

   assign is_block = (ctrl.mode == XM_BLOCK);
   assign is_succ  = (ctrl.mode == XM_SUCC);
   assign armed    = ctrl.en && ctrl.dual && !cnt_zero;
   assign start    = (state == ST_IDLE) && trig && armed;
   assign unit_end = (state == ST_WRITE) && bus_ack;
   assign blk_last = !is_block || (blk_left <= BW'(1));
   assign step     = unit_end;
   assign cnt_dec  = unit_end && blk_last;
   assign finish   = cnt_dec && cnt_one;
   assign bus_req  = (state != ST_IDLE);
   assign bus_we   = (state == ST_WRITE);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start) state_nx = ST_READ;
         ST_READ:  if (bus_ack) state_nx = ST_WRITE;
         ST_WRITE: if (bus_ack) begin
            if (finish)                    state_nx = ST_IDLE;
            else if (is_block && !blk_last) state_nx = ST_READ;
            else if (is_succ)              state_nx = ST_READ;
            else                           state_nx = ST_IDLE;
         end
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         blk_left <= '0;
         wdata    <= '0;
         done     <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= finish;
         if (start)
            blk_left <= (blklen == '0) ? BW'(1) : blklen;
         else if (unit_end && !blk_last)
            blk_left <= blk_left - BW'(1);
         if ((state == ST_READ) && bus_ack)
            wdata <= ctrl.unit_half ? bus_rdata : {8'h00, bus_rdata[7:0]};
      end
   end

   // R11: a pending bus cycle keeps its direction until acknowledged
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we)));

   // R8: completion flag lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an unarmed idle channel stays idle
   p_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !armed) |=> state == ST_IDLE);

   // R9: a running sequence is not restarted by a trigger
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ && !bus_ack) |=> state == ST_READ);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16,
   parameter int unsigned BW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic                trig,
   output logic                bus_req,
   output logic                bus_we,
   output logic                bus_half,
   output logic [AW-1:0]       bus_addr,
   output logic [UNIT_W-1:0]   bus_wdata,
   input  logic [UNIT_W-1:0]   bus_rdata,
   input  logic                bus_ack,
   output logic                done
);

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 2..32");
   end
   if (CW < 1 || CW > 32) begin : g_bad_cw
      $error("CW must lie in 1..32");
   end
   if (BW < 1 || BW > 32) begin : g_bad_bw
      $error("BW must lie in 1..32");
   end

   ctrl_t          ctrl;
   logic [BW-1:0]  blklen;
   logic [AW-1:0]  src_ptr, dst_ptr;
   logic [CW-1:0]  cnt;
   logic           cnt_zero, cnt_one;
   logic           step, cnt_dec, finish;
   logic           accept;
   logic [1:0]     ptr_load;

   assign accept   = reg_we && !ctrl.en;
   assign ptr_load = {accept && (reg_addr == OFS_DST), accept && (reg_addr == OFS_SRC)};

   dma_cfg_regs #(.BW(BW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .finish  (finish),
      .ctrl    (ctrl),
      .blklen  (blklen)
   );

   dma_addr_step #(.AW(AW)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (reg_wdata[AW-1:0]),
      .step     (step),
      .half     (ctrl.unit_half),
      .src_ptr  (src_ptr),
      .dst_ptr  (dst_ptr)
   );

   dma_count #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (reg_addr == OFS_CNT)),
      .load_val (reg_wdata[CW-1:0]),
      .dec      (cnt_dec),
      .cnt      (cnt),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one)
   );

   dma_xfer_fsm #(.BW(BW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .ctrl      (ctrl),
      .blklen    (blklen),
      .cnt_zero  (cnt_zero),
      .cnt_one   (cnt_one),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .wdata     (bus_wdata),
      .step      (step),
      .cnt_dec   (cnt_dec),
      .finish    (finish),
      .done      (done)
   );

   assign bus_addr = bus_we ? dst_ptr : src_ptr;
   assign bus_half = ctrl.unit_half;

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL: reg_rdata = 32'(ctrl);
         OFS_SRC:  reg_rdata = 32'(src_ptr);
         OFS_DST:  reg_rdata = 32'(dst_ptr);
         OFS_CNT:  reg_rdata = 32'(cnt);
         OFS_BLK:  reg_rdata = 32'(blklen);
         default:  reg_rdata = '0;
      endcase
   end

   // R8: completion and an enabled channel never coexist
   p_done_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ctrl.en);

   // R11: the address of a pending cycle does not move
   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> $stable(bus_addr));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

   localparam int CLK_NS = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_we = 0;
   logic [2:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        trig = 0;
   logic        bus_req, bus_we, bus_half, done;
   logic [31:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = 0;
   logic        bus_ack = 0;

   dma_chan_seq uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
      .bus_req(bus_req), .bus_we(bus_we), .bus_half(bus_half),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .done(done)
   );

   always #(CLK_NS/2) clk = ~clk;

   typedef struct {
      bit        we;
      bit [31:0] addr;
      bit [15:0] data;
      bit        half;
      string     req;
   } op_t;

   op_t   exp_q[$];
   int    n_chk = 0, n_fail = 0, n_done = 0, lat = 0, wait_left = 0;
   string cur_req = "R1";

   function automatic logic [15:0] mem_val(input logic [31:0] a);
      return (a[15:0] * 16'd3) ^ 16'h5A3C;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: memory responder and scoreboard
   always @(negedge clk) begin
      if (done) n_done++;
      if (bus_ack) begin
         bus_ack = 0;
         wait_left = lat;
      end
      if (!bus_req) wait_left = lat;
      else if (wait_left > 0) wait_left--;
      else begin
         bus_ack = 1;
         bus_rdata = mem_val(bus_addr);
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s unexpected bus cycle: actual we=%0d addr 0x%0h expected none",
                     cur_req, bus_we, bus_addr);
         end else begin
            op_t e;
            e = exp_q.pop_front();
            chk(e.req, "bus_we", 32'(bus_we), 32'(e.we));
            chk(e.req, "bus_addr", bus_addr, e.addr);
            chk("R6", "bus_half", 32'(bus_half), 32'(e.half));
            if (e.we) chk(e.req, "bus_wdata", 32'(bus_wdata), 32'(e.data));
         end
      end
   end

   task automatic do_reset();
      rst_n = 0;
      exp_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse();
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
   endtask

   task automatic drain();
      repeat (60) @(negedge clk);
      chk(cur_req, "scoreboard left", 32'(exp_q.size()), 32'd0);
   endtask

   // driver: push the unit sequence the requirements predict
   task automatic expect_units(input logic [31:0] s, input logic [31:0] d,
                               input int n, input bit half, input string req);
      for (int i = 0; i < n; i++) begin
         op_t r, w;
         logic [31:0] step;
         logic [15:0] v;
         step = half ? 32'(2*i) : 32'(i);
         v = mem_val(s + step);
         r.we = 0; r.addr = s + step; r.data = 0; r.half = half; r.req = "R11";
         w.we = 1; w.addr = d + step; w.data = half ? v : {8'h00, v[7:0]};
         w.half = half; w.req = req;
         exp_q.push_back(r);
         exp_q.push_back(w);
      end
   endtask

   function automatic logic [31:0] cw(bit en, bit dual, logic [1:0] mode, bit half);
      return {27'd0, half, mode, dual, en};
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int d0;
      do_reset();

      // R1 reset state
      cur_req = "R1";
      rd(3'd0, v); chk("R1", "ctrl", v, 32'd0);
      chk("R1", "done", 32'(done), 0);
      chk("R1", "bus_req", 32'(bus_req), 0);

      // R2/R6 single mode, bytes, no wait state
      cur_req = "R2"; lat = 0;
      wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 3);
      wr(3'd0, cw(1, 1, 2'b00, 0));
      expect_units(32'h100, 32'h200, 1, 0, "R2");
      pulse(); drain();
      rd(3'd3, v); chk("R2", "count after one trigger", v, 2);
      rd(3'd1, v); chk("R6", "byte src step", v, 32'h101);
      rd(3'd2, v); chk("R6", "byte dst step", v, 32'h201);
      d0 = n_done;
      expect_units(32'h101, 32'h201, 1, 0, "R2"); pulse(); drain();
      expect_units(32'h102, 32'h202, 1, 0, "R2"); pulse(); drain();
      cur_req = "R8";
      chk("R8", "done pulses", 32'(n_done - d0), 1);
      rd(3'd0, v); chk("R8", "enable cleared", v, cw(0, 1, 2'b00, 0));
      rd(3'd3, v); chk("R8", "count zero", v, 0);
      pulse(); drain();
      chk("R8", "no done after finish", 32'(n_done - d0), 1);

      // R3/R6 successive mode, half-words, one wait state
      cur_req = "R3"; lat = 1;
      wr(3'd1, 32'h400); wr(3'd2, 32'h800); wr(3'd3, 4);
      wr(3'd0, cw(1, 1, 2'b01, 1));
      d0 = n_done;
      expect_units(32'h400, 32'h800, 4, 1, "R3");
      pulse(); drain();
      rd(3'd3, v); chk("R3", "count", v, 0);
      rd(3'd1, v); chk("R6", "half src step", v, 32'h408);
      rd(3'd2, v); chk("R6", "half dst step", v, 32'h808);
      chk("R3", "done pulses", 32'(n_done - d0), 1);

      // R4 block mode, two blocks of three bytes
      cur_req = "R4"; lat = 0;
      wr(3'd1, 32'h1000); wr(3'd2, 32'h2000); wr(3'd3, 2); wr(3'd4, 3);
      wr(3'd0, cw(1, 1, 2'b10, 0));
      rd(3'd4, v); chk("R4", "block length", v, 3);
      d0 = n_done;
      expect_units(32'h1000, 32'h2000, 3, 0, "R4");
      pulse(); drain();
      rd(3'd3, v); chk("R4", "count after first block", v, 1);
      rd(3'd0, v); chk("R4", "still enabled", v, cw(1, 1, 2'b10, 0));
      expect_units(32'h1003, 32'h2003, 3, 0, "R4");
      pulse(); drain();
      rd(3'd3, v); chk("R4", "count after second block", v, 0);
      chk("R4", "done pulses", 32'(n_done - d0), 1);

      // R5 reserved mode acts as single; R7 locked writes
      cur_req = "R5"; lat = 1;
      wr(3'd1, 32'h3000); wr(3'd2, 32'h3100); wr(3'd3, 2);
      wr(3'd0, cw(1, 1, 2'b11, 0));
      expect_units(32'h3000, 32'h3100, 1, 0, "R5");
      pulse(); drain();
      rd(3'd3, v); chk("R5", "one unit per trigger", v, 1);
      cur_req = "R7";
      wr(3'd1, 32'hDEAD); wr(3'd0, cw(0, 0, 2'b01, 1)); wr(3'd3, 9); wr(3'd4, 7);
      rd(3'd1, v); chk("R7", "src unchanged", v, 32'h3001);
      rd(3'd0, v); chk("R7", "ctrl unchanged", v, cw(1, 1, 2'b11, 0));
      rd(3'd3, v); chk("R7", "count unchanged", v, 1);
      rd(3'd4, v); chk("R7", "block length unchanged", v, 3);
      expect_units(32'h3001, 32'h3101, 1, 0, "R7");
      pulse(); drain();

      // R9 trigger during a running unit is dropped
      cur_req = "R9"; lat = 1;
      wr(3'd1, 32'h500); wr(3'd2, 32'h600); wr(3'd3, 3);
      wr(3'd0, cw(1, 1, 2'b00, 0));
      expect_units(32'h500, 32'h600, 1, 0, "R9");
      pulse(); pulse(); drain();
      rd(3'd3, v); chk("R9", "count after busy trigger", v, 2);

      // R10 disarmed channel: dual bit clear
      do_reset();
      cur_req = "R10";
      wr(3'd1, 32'h700); wr(3'd3, 2);
      wr(3'd0, cw(1, 0, 2'b00, 0));
      pulse(); drain();
      rd(3'd3, v); chk("R10", "count with dual clear", v, 2);
      rd(3'd1, v); chk("R10", "src with dual clear", v, 32'h700);

      // R10 count zero, then enable clear
      do_reset();
      wr(3'd0, cw(1, 1, 2'b01, 0));
      d0 = n_done;
      pulse(); drain();
      chk("R10", "no done with zero count", 32'(n_done - d0), 0);
      do_reset();
      wr(3'd3, 5); wr(3'd0, cw(0, 1, 2'b01, 0));
      pulse(); drain();
      rd(3'd3, v); chk("R10", "count with enable clear", v, 5);

      summary();
      $finish;
   end

endmodule